// File: doc/BRIEF.md
# Polyphase Filter Tap-History Controller

This block keeps the sample history that the multiply-accumulate stage of a polyphase prefilter needs. Input samples arrive one per valid cycle and are assigned cyclically to slots. A slot is a band, or a (band, channel) pair when several time-multiplexed channels share each band. Consecutive samples fill the channels of one band before moving to the next band. For every slot the block holds the newest `NTAPS` samples as one wide word in a tap-history memory. That memory is modelled inside the block.

On each valid sample the block reads the slot's word and drops the oldest sample. It puts the new one in the top position and writes the word back. The updated word leaves the block together with the coefficient read address for the slot's band and an output valid. One controller serves `NSTREAMS` parallel streams. The streams share the slot addressing and the write enable, and each stream has its own history memory. The coefficient memories and the multiply-accumulate logic sit outside this block.

Top module: `ppf_tap_hist_ctrl`

## Requirements
- R1: `hist_vec` carries stream s in bits [s*DAT_W*NTAPS +: DAT_W*NTAPS]. Inside that word, tap position j occupies [j*DAT_W +: DAT_W]. Position NTAPS-1 holds the newest sample and position 0 the oldest.
- R2: For each valid sample, the word presented for its slot equals the slot's previous word with every position moved down by one. The former position 0 is discarded and the new sample goes into position NTAPS-1.
- R3: The slot index starts at 0 and advances by one per valid sample through DEPTH = NBANDS*2^CHAN_LOG2 slots. Each slot keeps its own history, so a sample comes back as history exactly DEPTH valid samples later.
- R4: `coef_addr` equals the slot index shifted right by CHAN_LOG2, which is the band index. It stays constant across the 2^CHAN_LOG2 channels of a band and is always below NBANDS.
- R5: `out_val` rises exactly once for each valid input, RD_LAT+1 clock cycles after the cycle in which `in_val` was high. Otherwise it is low.
- R6: While `in_val` is low, the slot index holds, no history changes, `in_dat` is ignored and no output is produced.
- R7: After slot DEPTH-1 the next valid sample uses slot 0 again.
- R8: Synchronous active-high reset clears the slot index, the pipeline, the registered outputs and every history word to zero.
- R9: Parallel streams share slot and coefficient addressing, but each stream's history is built only from that stream's own samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous active-high reset |
| in_dat | input | NSTREAMS*DAT_W | One new sample per stream, stream s in [s*DAT_W +: DAT_W] |
| in_val | input | 1 | Samples on `in_dat` are valid |
| hist_vec | output | NSTREAMS*DAT_W*NTAPS | Updated tap history of the current slot, all streams |
| coef_addr | output | ceil(log2(NBANDS)) | Coefficient read address (band index) for that slot |
| out_val | output | 1 | `hist_vec` and `coef_addr` are valid |

## Verification
The bench drives unbroken runs of valid samples, because a slot then returns after the shortest gap and a missing or late write-back would show up as stale history. It inserts idle cycles carrying junk data. A design that moved the slot counter or wrote memory without a valid would misalign bands or leak junk into a later history word. It checks the wrap from the last slot to slot 0, and band addresses that must hold steady across channels. It also checks a reset during traffic, after which any history left behind would appear in the first words.

// File: rtl/ppf_hist_pkg.sv
package ppf_hist_pkg;

    // Address width for n entries, never below one bit.
    function automatic int unsigned width_of(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Number of history slots: bands times multiplexed channels.
    function automatic int unsigned slot_total(input int unsigned nbands,
                                               input int unsigned chan_log2);
        return nbands * (1 << chan_log2);
    endfunction

endpackage

// File: rtl/tap_slot_counter.sv
module tap_slot_counter #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [ADDR_W-1:0] slot
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (adv)
            slot <= (slot == LAST) ? '0 : slot + 1'b1;
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(slot)); // R6
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && slot == LAST) |=> slot == '0); // R7
endmodule

// File: rtl/tap_dly_line.sv
module tap_dly_line #(
    parameter int unsigned W = 8,
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < N; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[N-1];
endmodule

// File: rtl/tap_hist_ram.sv
module tap_hist_ram #(
    parameter int unsigned W      = 24,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data
);
    logic [W-1:0] mem     [DEPTH];
    logic [W-1:0] rd_pipe [RD_LAT];

    // Storage is cleared on reset so every history starts at zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RD_LAT; i++) rd_pipe[i] <= '0;
        end else begin
            rd_pipe[0] <= mem[rd_addr];
            for (int i = 1; i < RD_LAT; i++) rd_pipe[i] <= rd_pipe[i-1];
        end
    end

    assign rd_data = rd_pipe[RD_LAT-1];
endmodule

// File: rtl/tap_shift_unit.sv
module tap_shift_unit #(
    parameter int unsigned DAT_W = 8,
    parameter int unsigned NTAPS = 3
) (
    input  logic [DAT_W*NTAPS-1:0] old_word,
    input  logic [DAT_W-1:0]       sample,
    output logic [DAT_W*NTAPS-1:0] new_word
);
    localparam int unsigned WORD_W = DAT_W * NTAPS;

    // Oldest sample falls off the bottom, newest enters at the top.
    always_comb begin
        new_word = WORD_W'({sample, old_word} >> DAT_W);
    end
endmodule

// File: rtl/ppf_tap_hist_ctrl.sv
module ppf_tap_hist_ctrl
    import ppf_hist_pkg::*;
#(
    parameter int unsigned DAT_W     = 8,
    parameter int unsigned NTAPS     = 3,
    parameter int unsigned NBANDS    = 4,
    parameter int unsigned CHAN_LOG2 = 1,
    parameter int unsigned NSTREAMS  = 2,
    parameter int unsigned RD_LAT    = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NSTREAMS*DAT_W-1:0]       in_dat,
    input  logic                            in_val,
    output logic [NSTREAMS*DAT_W*NTAPS-1:0] hist_vec,
    output logic [width_of(NBANDS)-1:0]     coef_addr,
    output logic                            out_val
);
    localparam int unsigned DEPTH  = slot_total(NBANDS, CHAN_LOG2);
    localparam int unsigned ADDR_W = width_of(DEPTH);
    localparam int unsigned CA_W   = width_of(NBANDS);
    localparam int unsigned WORD_W = DAT_W * NTAPS;
    localparam int unsigned IN_W   = NSTREAMS * DAT_W;
    localparam int unsigned CNT_W  = width_of(RD_LAT + 2) + 1;

    // A slot must not return before its previous write-back lands.
    if (RD_LAT < 1 || DEPTH <= RD_LAT) begin : g_bad_cfg
        $error("ppf_tap_hist_ctrl: need 1 <= RD_LAT < slot count");
    end

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] slot;
        logic [IN_W-1:0]   dat;
    } stage_t;

    logic [ADDR_W-1:0]        slot_now;
    stage_t                   stg_in, stg_out;
    logic [NSTREAMS*WORD_W-1:0] upd_bus;

    tap_slot_counter #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_slot (
        .clk(clk), .rst(rst), .adv(in_val), .slot(slot_now)
    );

    assign stg_in = '{vld: in_val, slot: slot_now, dat: in_dat};

    // Sample, slot and valid travel alongside the memory read latency.
    tap_dly_line #(.W($bits(stage_t)), .N(RD_LAT)) u_align (
        .clk(clk), .rst(rst), .din(stg_in), .dout(stg_out)
    );

    for (genvar s = 0; s < NSTREAMS; s++) begin : g_stream
        logic [WORD_W-1:0] old_word;

        tap_hist_ram #(.W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_ram (
            .clk(clk), .rst(rst),
            .rd_addr(slot_now), .rd_data(old_word),
            .wr_en(stg_out.vld), .wr_addr(stg_out.slot),
            .wr_data(upd_bus[s*WORD_W +: WORD_W])
        );

        tap_shift_unit #(.DAT_W(DAT_W), .NTAPS(NTAPS)) u_shift (
            .old_word(old_word),
            .sample(stg_out.dat[s*DAT_W +: DAT_W]),
            .new_word(upd_bus[s*WORD_W +: WORD_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_val   <= 1'b0;
            hist_vec  <= '0;
            coef_addr <= '0;
        end else begin
            out_val <= stg_out.vld;
            if (stg_out.vld) begin
                hist_vec  <= upd_bus;
                coef_addr <= stg_out.slot[ADDR_W-1 -: CA_W];
            end
        end
    end

    // Samples accepted but not yet presented, used by the checks below.
    logic [CNT_W-1:0] pend;
    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else
            pend <= pend + CNT_W'(in_val) - CNT_W'(out_val);
    end

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst)
        pend <= CNT_W'(RD_LAT + 1)); // R5
    AST_NO_SPURIOUS_VAL: assert property (@(posedge clk) disable iff (rst)
        out_val |-> pend != '0); // R5
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_val); // R8
    AST_COEF_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_val |-> 32'(coef_addr) < NBANDS); // R4
endmodule

// File: tb/sim_ppf_tap_hist_ctrl.sv
module sim_ppf_tap_hist_ctrl;
    localparam int DAT_W     = 8;
    localparam int NTAPS     = 3;
    localparam int NBANDS    = 4;
    localparam int CHAN_LOG2 = 1;
    localparam int NSTREAMS  = 2;
    localparam int RD_LAT    = 2;
    localparam int DEPTH     = NBANDS * (1 << CHAN_LOG2);
    localparam int WORD_W    = DAT_W * NTAPS;
    localparam int IN_W      = NSTREAMS * DAT_W;
    localparam int HW        = NSTREAMS * WORD_W;
    localparam int CA_W      = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [IN_W-1:0] in_dat = '0;
    logic            in_val = 1'b0;
    logic [HW-1:0]   hist_vec;
    logic [CA_W-1:0] coef_addr;
    logic            out_val;

    ppf_tap_hist_ctrl #(
        .DAT_W(DAT_W), .NTAPS(NTAPS), .NBANDS(NBANDS),
        .CHAN_LOG2(CHAN_LOG2), .NSTREAMS(NSTREAMS), .RD_LAT(RD_LAT)
    ) u0 (
        .clk(clk), .rst(rst), .in_dat(in_dat), .in_val(in_val),
        .hist_vec(hist_vec), .coef_addr(coef_addr), .out_val(out_val)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [HW-1:0]   h;
        logic [CA_W-1:0] c;
        int              due;
    } exp_t;

    exp_t              q[$];
    logic [WORD_W-1:0] mdl [NSTREAMS][DEPTH];
    int                mslot = 0;
    int                cyc = 0;
    int                n_chk = 0;
    int                n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic model_clear();
        for (int s = 0; s < NSTREAMS; s++)
            for (int k = 0; k < DEPTH; k++) mdl[s][k] = '0;
        mslot = 0;
    endtask

    // One input cycle; model updates only on valid samples (R2, R3, R6, R7).
    task automatic step(input bit v, input logic [IN_W-1:0] d);
        exp_t e;
        @(negedge clk);
        in_val = v;
        in_dat = d;
        if (v) begin
            for (int s = 0; s < NSTREAMS; s++) begin
                mdl[s][mslot] = (mdl[s][mslot] >> DAT_W) |
                    (WORD_W'(d[s*DAT_W +: DAT_W]) << (WORD_W - DAT_W));
                e.h[s*WORD_W +: WORD_W] = mdl[s][mslot];
            end
            e.c   = CA_W'(mslot >> CHAN_LOG2);
            e.due = cyc + RD_LAT + 1;
            q.push_back(e);
            mslot = (mslot == DEPTH - 1) ? 0 : mslot + 1;
        end
    endtask

    function automatic logic [IN_W-1:0] pat(input int i, input int salt);
        logic [IN_W-1:0] d;
        d[0 +: DAT_W]     = DAT_W'(i * 7 + 1 + salt);
        d[DAT_W +: DAT_W] = DAT_W'(i * 13 + 5 + salt) ^ 8'hA5;
        return d;
    endfunction

    // Output monitor: sampled at the falling edge, away from register updates.
    always @(negedge clk) begin
        if (!rst) begin
            if (out_val) begin
                n_chk++;
                if (q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R5 R6: out_val=1 expected 0 at cycle %0d", cyc);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.due != cyc) begin
                        n_fail++;
                        $display("FAIL R5: output at cycle %0d expected %0d", cyc, e.due);
                    end
                    n_chk++;
                    if (coef_addr !== e.c) begin
                        n_fail++;
                        $display("FAIL R4: coef_addr=%0d expected %0d", coef_addr, e.c);
                    end
                    for (int s = 0; s < NSTREAMS; s++) begin
                        n_chk++;
                        if (hist_vec[s*WORD_W +: WORD_W] !== e.h[s*WORD_W +: WORD_W]) begin
                            n_fail++;
                            $display("FAIL R1 R2 R3 R9 stream %0d: hist=%h expected %h",
                                     s, hist_vec[s*WORD_W +: WORD_W], e.h[s*WORD_W +: WORD_W]);
                        end
                    end
                end
            end else if (q.size() != 0 && q[0].due == cyc) begin
                n_chk++;
                n_fail++;
                $display("FAIL R5: out_val=0 expected 1 at cycle %0d", cyc);
            end
        end
    end

    task automatic drain();
        for (int i = 0; i < RD_LAT + 3; i++) step(1'b0, '1);
        n_chk++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R5: %0d outputs missing, expected 0", q.size());
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1;
        rst = 1'b1;
        in_val = 1'b0;
        q.delete();
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (out_val !== 1'b0 || hist_vec !== '0 || coef_addr !== '0) begin
            n_fail++;
            $display("FAIL R8: val=%b hist=%h coef=%0d expected 0 0 0",
                     out_val, hist_vec, coef_addr);
        end
    endtask

    // Back-to-back samples: fastest slot reuse, several wraps (R2, R3, R7, R9).
    task automatic t_stream();
        for (int i = 0; i < 5 * DEPTH; i++) step(1'b1, pat(i, 0));
        drain();
    endtask

    // Idle cycles carrying junk must not move slots or touch history (R6).
    task automatic t_gaps();
        for (int i = 0; i < 6 * DEPTH; i++) begin
            if (i % 3 == 1) step(1'b0, 16'hDEAD);
            else            step(1'b1, pat(i, 40));
        end
        for (int i = 0; i < 20; i++) step(1'b0, IN_W'(i * 977));
        for (int i = 0; i < 2 * DEPTH; i++) step(1'b1, pat(i, 90));
        drain();
    endtask

    // Reset with samples in flight, then check history restarts at zero (R8).
    task automatic t_mid_reset();
        for (int i = 0; i < DEPTH + 3; i++) step(1'b1, pat(i, 17));
        do_reset();
        for (int i = 0; i < 2 * DEPTH + 1; i++) step(1'b1, pat(i, 55));
        drain();
    endtask

    initial begin : watchdog
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();
        t_stream();
        t_gaps();
        t_mid_reset();
        t_stream();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule